// File: doc/BRIEF.md
# Daisy-Chain Command Word Sequencer

This block sits on the host side of a serial link that reaches a string of hashing chips wired in a daisy chain. For each chip it produces the shortest command sequence that keeps the chip busy. First it sends a job. Then it reads back one result. Then it polls the chip's queue state. Every command is emitted as a stream of 16-bit words. Each command ends with filler words that carry it down the chain to its target, so the further down the chain a chip sits, the longer its commands become.

The host gives the chain length, a target chip and a mode bit, then pulses `start`. In single mode only the target chip is served. In round mode the block serves every chip from the first to the last in turn. Words leave through a valid/ready port towards a serial shifter. Words that come back from the chain while filler is being shifted are captured and shown on a reply port. At the end of the sequence a one-cycle pulse is raised, and it comes with the number of words that were sent. A start request whose arguments do not describe a reachable chip is refused, and an error flag is raised.

Top module: `spi_chain_seq`

## Requirements
- R1: The first word of each command carries the opcode in bits 15:8 and the chip index in bits 7:0. The opcodes are 0x07 for a job, 0x08 for a result read and 0x0A for a queue-state read. The result read is a broadcast with index 0x00, while the job and the queue read carry the target index. All other words of a command are 0x0000.
- R2: Command bodies are 30 words for a job, 4 words for a result read and 5 words for a queue read. `word_pad` is low on body words.
- R3: Filler follows each body, with `word_pad` high and the data 0x0000. A unicast to chip N has 2N-1 filler words, and a broadcast in a chain of M chips has 2M.
- R4: For one chip N, the block sends the job, then the result read, then the queue read, for 37+4N+2M words in all.
- R5: In round mode, chips 1 to M are served in ascending order, and the round totals M(4M+39) words.
- R6: While `word_valid` is high and `word_ready` is low, the word and its flags hold. The stream advances only on a handshake. `word_last` marks the final word of every command.
- R7: When a filler word is accepted, `reply_in` from that cycle appears on `rx_word` in the next cycle, together with a one-cycle `rx_valid`. Body handshakes give no `rx_valid`.
- R8: A start is refused when M is 0, when M exceeds the MAX_CHIPS parameter (254 by default), or when single mode has N = 0 or N > M. A refused start sends no word and sets `err`. The next accepted start clears `err`.
- R9: A start request while the block is busy has no effect on the stream or on the total.
- R10: After reset, `word_valid`, `busy`, `done`, `err` and `rx_valid` are low. One cycle after the last handshake, `done` pulses for one cycle, `word_valid` is low and `words_total` holds the count of words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a sequence |
| round_all | input | 1 | 1: serve chips 1..M; 0: serve the target chip only |
| chain_len | input | 8 | Number of chips M in the chain |
| target | input | 8 | Target chip index N, counted from 1 |
| word_data | output | 16 | Word offered to the shifter |
| word_valid | output | 1 | Word offered |
| word_ready | input | 1 | Shifter accepts the word |
| word_pad | output | 1 | Current word is filler |
| word_last | output | 1 | Current word ends a command |
| reply_in | input | 16 | Word returned by the chain during the current transfer |
| rx_word | output | 16 | Captured returned word |
| rx_valid | output | 1 | Captured word is new |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last start request was refused |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| words_total | output | 19 | Words sent in the current or last sequence |

## Verification
On every cycle, the assertions check the port-level rules. A stalled word holds still, filler words are zero, every command ends on filler, and opcodes come from the three legal values. They also check that a reply strobe follows only an accepted filler word, that `done` follows only a final handshake, and that an error never coincides with an offered word. Only the bench's scenarios can show that the word count matches each chip's position, that the commands come in the right order across chips, and that the totals equal 37+4N+2M and M(4M+39). The same holds for the refusal rules and the ignoring of a start while busy. For this the bench sweeps every target in small chains, full rounds in chains of up to eight chips and the 254-chip boundary, with both a steady and a stalling shifter.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int OP_W   = 8;
  localparam int CHIP_W = 8;
  localparam int WORD_W = OP_W + CHIP_W;

  localparam int LEN_JOB = 30;
  localparam int LEN_RES = 4;
  localparam int LEN_QUE = 5;

  typedef enum logic [1:0] {CMD_JOB = 2'd0, CMD_RES = 2'd1, CMD_QUE = 2'd2} cmd_e;

  function automatic logic [OP_W-1:0] opcode_of(cmd_e c);
    case (c)
      CMD_JOB: opcode_of = 8'h07;
      CMD_RES: opcode_of = 8'h08;
      default: opcode_of = 8'h0A;
    endcase
  endfunction

  function automatic int body_of(cmd_e c);
    case (c)
      CMD_JOB: body_of = LEN_JOB;
      CMD_RES: body_of = LEN_RES;
      default: body_of = LEN_QUE;
    endcase
  endfunction

  // broadcast filler scales with chain length, unicast with target depth
  function automatic int total_of(cmd_e c, int chip, int m);
    if (c == CMD_RES) total_of = body_of(c) + 2 * m;
    else              total_of = body_of(c) + 2 * chip - 1;
  endfunction
endpackage

// File: rtl/spi_chain_arg_check.sv
module spi_chain_arg_check import spi_chain_pkg::*; #(
  parameter int MAX_CHIPS = 254
) (
  input  logic              round_all,
  input  logic [CHIP_W-1:0] chain_len,
  input  logic [CHIP_W-1:0] target,
  output logic              args_ok
);
  logic len_ok, tgt_ok;

  always_comb begin
    len_ok  = (chain_len != '0) && (int'(chain_len) <= MAX_CHIPS);
    tgt_ok  = round_all || ((target != '0) && (target <= chain_len));
    args_ok = len_ok && tgt_ok;
  end
endmodule

// File: rtl/spi_chain_walk.sv
module spi_chain_walk import spi_chain_pkg::*; #(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHIP_W-1:0] load_m,
  input  logic [CHIP_W-1:0] load_n,
  input  logic              load_all,
  input  logic              ready,
  output logic              act,
  output logic [WORD_W-1:0] word,
  output logic              pad,
  output logic              last,
  output logic              hs,
  output logic              round_end
);
  cmd_e              cmd_q, cmd_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CHIP_W-1:0] chip_q, chip_n, m_q, m_n, field_n;
  logic              act_q, act_n, all_q, all_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              pad_q, pad_n, last_q, last_n;
  logic              cur_last, more_chips;

  always_comb begin
    cur_last   = (int'(idx_q) == total_of(cmd_q, int'(chip_q), int'(m_q)) - 1);
    more_chips = all_q && (chip_q < m_q);
    hs         = act_q && ready;
    round_end  = hs && cur_last && (cmd_q == CMD_QUE) && !more_chips;

    act_n  = act_q;
    cmd_n  = cmd_q;
    idx_n  = idx_q;
    chip_n = chip_q;
    m_n    = m_q;
    all_n  = all_q;
    if (load) begin
      act_n  = 1'b1;
      cmd_n  = CMD_JOB;
      idx_n  = '0;
      chip_n = load_all ? CHIP_W'(1) : load_n;
      m_n    = load_m;
      all_n  = load_all;
    end else if (hs) begin
      if (!cur_last) begin
        idx_n = idx_q + IDX_W'(1);
      end else begin
        idx_n = '0;
        case (cmd_q)
          CMD_JOB: cmd_n = CMD_RES;
          CMD_RES: cmd_n = CMD_QUE;
          default: begin
            cmd_n = CMD_JOB;
            if (more_chips) chip_n = chip_q + CHIP_W'(1);
            else            act_n  = 1'b0;
          end
        endcase
      end
    end

    // output decode from next state, so the ports leave flops directly
    field_n = (cmd_n == CMD_RES) ? '0 : chip_n;
    word_n  = (act_n && idx_n == '0) ? {opcode_of(cmd_n), field_n} : '0;
    pad_n   = act_n && (int'(idx_n) >= body_of(cmd_n));
    last_n  = act_n && (int'(idx_n) == total_of(cmd_n, int'(chip_n), int'(m_n)) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cmd_q  <= CMD_JOB;
      idx_q  <= '0;
      chip_q <= '0;
      m_q    <= '0;
      all_q  <= 1'b0;
      word_q <= '0;
      pad_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      cmd_q  <= cmd_n;
      idx_q  <= idx_n;
      chip_q <= chip_n;
      m_q    <= m_n;
      all_q  <= all_n;
      word_q <= word_n;
      pad_q  <= pad_n;
      last_q <= last_n;
    end
  end

  assign act  = act_q;
  assign word = word_q;
  assign pad  = pad_q;
  assign last = last_q;
endmodule

// File: rtl/spi_chain_tally.sv
module spi_chain_tally #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             hs,
  input  logic             round_end,
  output logic             done,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] count_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      count_q <= clear ? '0 : count_q + CNT_W'(hs);
      done_q  <= round_end;
    end
  end

  assign done  = done_q;
  assign total = count_q;
endmodule

// File: rtl/spi_chain_seq.sv
module spi_chain_seq import spi_chain_pkg::*; #(
  parameter int MAX_CHIPS = 254,
  localparam int IDX_W = $clog2(LEN_JOB + 2 * MAX_CHIPS),
  localparam int CNT_W = $clog2(MAX_CHIPS * (4 * MAX_CHIPS + 39) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              round_all,
  input  logic [CHIP_W-1:0] chain_len,
  input  logic [CHIP_W-1:0] target,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              word_pad,
  output logic              word_last,
  input  logic [WORD_W-1:0] reply_in,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              busy,
  output logic              err,
  output logic              done,
  output logic [CNT_W-1:0]  words_total
);
  logic args_ok, accept, reject, act, hs, round_end;
  logic err_q, rx_valid_q;
  logic [WORD_W-1:0] rx_word_q;

  spi_chain_arg_check #(.MAX_CHIPS(MAX_CHIPS)) u_check (
    .round_all(round_all), .chain_len(chain_len), .target(target), .args_ok(args_ok)
  );

  assign accept = start && !act && args_ok;
  assign reject = start && !act && !args_ok;

  spi_chain_walk #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst(rst), .load(accept), .load_m(chain_len), .load_n(target),
    .load_all(round_all), .ready(word_ready), .act(act), .word(word_data),
    .pad(word_pad), .last(word_last), .hs(hs), .round_end(round_end)
  );

  spi_chain_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clear(accept), .hs(hs), .round_end(round_end),
    .done(done), .total(words_total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q      <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_word_q  <= '0;
    end else begin
      if (accept)      err_q <= 1'b0;
      else if (reject) err_q <= 1'b1;
      rx_valid_q <= hs && word_pad;
      if (hs && word_pad) rx_word_q <= reply_in;
    end
  end

  assign word_valid = act;
  assign busy       = act;
  assign err        = err_q;
  assign rx_valid   = rx_valid_q;
  assign rx_word    = rx_word_q;
endmodule

// File: rtl/spi_chain_seq_chk.sv
module spi_chain_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] word_data,
  input logic        word_valid,
  input logic        word_ready,
  input logic        word_pad,
  input logic        word_last,
  input logic        rx_valid,
  input logic        err,
  input logic        done
);
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    word_valid && !word_ready |=> word_valid && $stable(word_data) && $stable(word_pad) && $stable(word_last));

  a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
    word_valid && word_pad |-> word_data == 16'h0000);

  a_r3_ends_in_pad: assert property (@(posedge clk) disable iff (rst)
    word_valid && word_last |-> word_pad);

  a_r1_legal_opcode: assert property (@(posedge clk) disable iff (rst)
    word_valid && !word_pad && word_data != 16'h0000 |->
      (word_data[15:8] == 8'h07 || word_data[15:8] == 8'h08 || word_data[15:8] == 8'h0A));

  a_r7_reply_after_pad: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(word_valid && word_ready && word_pad));

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(word_valid && word_ready && word_last) && !word_valid);

  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> !word_valid);
endmodule

bind spi_chain_seq spi_chain_seq_chk u_chk (
  .clk(clk), .rst(rst), .word_data(word_data), .word_valid(word_valid),
  .word_ready(word_ready), .word_pad(word_pad), .word_last(word_last),
  .rx_valid(rx_valid), .err(err), .done(done)
);

// File: tb/spi_chain_seq_bench.sv
module spi_chain_seq_bench;
  localparam int MAXC  = 254;
  localparam int CNT_W = $clog2(MAXC * (4 * MAXC + 39) + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, round_all = 1'b0, word_ready = 1'b0;
  logic [7:0] chain_len = '0, target = '0;
  logic [15:0] reply_in = '0;
  logic [15:0] word_data, rx_word;
  logic word_valid, word_pad, word_last, rx_valid, busy, err, done;
  logic [CNT_W-1:0] words_total;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  spi_chain_seq #(.MAX_CHIPS(MAXC)) u_spi_chain_seq (
    .clk(clk), .rst(rst), .start(start), .round_all(round_all), .chain_len(chain_len),
    .target(target), .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .word_pad(word_pad), .word_last(word_last), .reply_in(reply_in), .rx_word(rx_word),
    .rx_valid(rx_valid), .busy(busy), .err(err), .done(done), .words_total(words_total)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] op_for(int c);
    return (c == 0) ? 8'h07 : (c == 1) ? 8'h08 : 8'h0A;
  endfunction

  // rmode 0: shifter always ready; 1: pseudo-random stalls. poke: start while busy (R9)
  task automatic run(int m, int n, bit all, int rmode, bit poke);
    int ch, cm, ix, iter, body, len, exp_total;
    bit fin, ppad, rdy;
    logic [15:0] prep, ew;
    string tg;
    @(negedge clk);
    start = 1'b1; chain_len = m[7:0]; target = n[7:0]; round_all = all; word_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    ch = all ? 1 : n; cm = 0; ix = 0; iter = 0; fin = 0; ppad = 0; prep = '0;
    exp_total = all ? m * (4 * m + 39) : 37 + 4 * n + 2 * m;
    tg = poke ? "R9" : (all ? "R5" : "R4");
    while (!fin && iter < 20000) begin
      body = (cm == 0) ? 30 : (cm == 1) ? 4 : 5;
      len  = body + ((cm == 1) ? 2 * m : 2 * ch - 1);
      ew   = (ix == 0) ? {op_for(cm), (cm == 1) ? 8'h00 : ch[7:0]} : 16'h0000;
      chk("R6 valid", int'(word_valid), 1);
      chk("R1 word", int'(word_data), int'(ew));
      chk("R2 R3 pad flag", int'(word_pad), int'(ix >= body));
      chk("R6 last flag", int'(word_last), int'(ix == len - 1));
      chk("R7 rx_valid", int'(rx_valid), int'(ppad));
      if (ppad) chk("R7 rx_word", int'(rx_word), int'(prep));
      if (iter == 0) chk("R8 err cleared", int'(err), 0);
      rdy = (rmode == 0) ? 1'b1 : lf[0];
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      word_ready = rdy;
      reply_in = 16'hC000 + 16'(iter);
      if (poke && iter == 6) begin
        start = 1'b1; chain_len = 8'd1; target = 8'd1; round_all = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      if (rdy) begin
        ppad = (ix >= body);
        prep = reply_in;
        if (ix < len - 1) ix++;
        else begin
          ix = 0;
          if (cm < 2) cm++;
          else begin
            cm = 0;
            if (all && ch < m) ch++;
            else fin = 1;
          end
        end
      end else ppad = 0;
      iter++;
    end
    if (!fin) chk({tg, " sequence finished"}, 0, 1);
    chk("R10 done pulse", int'(done), 1);
    chk({tg, " words_total"}, int'(words_total), exp_total);
    chk("R10 idle after last", int'(word_valid), 0);
    chk("R7 rx_valid last pad", int'(rx_valid), 1);
    chk("R7 rx_word last pad", int'(rx_word), int'(prep));
    word_ready = 1'b0;
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
    chk("R10 stays idle", int'(word_valid), 0);
  endtask

  task automatic reject(int m, int n, bit all);
    @(negedge clk);
    start = 1'b1; chain_len = m[7:0]; target = n[7:0]; round_all = all;
    @(negedge clk);
    start = 1'b0;
    chk("R8 err raised", int'(err), 1);
    chk("R8 no word", int'(word_valid), 0);
    @(negedge clk);
    chk("R8 still no word", int'(word_valid), 0);
    chk("R8 not busy", int'(busy), 0);
    chk("R8 err held", int'(err), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(word_valid), 0);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset err", int'(err), 0);
    chk("R10 reset rx_valid", int'(rx_valid), 0);
    rst = 1'b0;

    for (int m = 1; m <= 5; m++)
      for (int n = 1; n <= m; n++)
        run(m, n, 1'b0, (m + n) % 2, n == 1);
    for (int m = 1; m <= 8; m++) begin
      run(m, 0, 1'b1, 0, 1'b0);
      if (m <= 4) run(m, 3, 1'b1, 1, m == 2);
    end
    run(254, 254, 1'b0, 0, 1'b0);
    run(254, 1, 1'b0, 1, 1'b0);

    reject(3, 0, 1'b0);
    run(2, 2, 1'b0, 0, 1'b0);
    reject(3, 4, 1'b0);
    reject(0, 1, 1'b1);
    reject(255, 1, 1'b0);
    reject(255, 0, 1'b1);
    run(1, 1, 1'b0, 1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule